// File: doc/BRIEF.md
# Dual-Window Video Memory Address Translator

This block sits between a host request port and two 32-bit video memory banks that together hold 8 MB. The host sees the same storage through two aliasing windows, chosen by host address bit 24. With bit 24 set, the window is sequential: the low 4 MB of offsets reach the first bank and the upper 4 MB reach the second. With bit 24 clear, the window is interleaved: consecutive 32-bit words alternate between the banks, starting with the first bank. Every storage cell can therefore be reached from both windows.

The host presents an address, write data, a write flag and a size of 8, 16, 32 or 64 bits. The block turns each request into per-bank enable, write, word address, byte-enable and data lines. The banks are plain synchronous RAMs that return read data one cycle later. The block then aligns that data back into the width the host asked for. An 8-bit write, or a 64-bit access in the sequential window, reaches no bank and raises a one-cycle error flag.

Top module: `vram_dual_bank_xlat`

## Requirements
- R1: Sequential window (req_addr[24]=1), sizes 8/16/32: offset o (req_addr[22:0]) selects bank lo when o[22]=0 and bank hi when o[22]=1, at word address o[21:2], in the same cycle as the request.
- R2: Interleaved window (req_addr[24]=0), sizes 8/16/32: bank lo when o[2]=0 and bank hi when o[2]=1, at word address o[22:3], in the same cycle.
- R3: Interleaved word 2k is the same cell as sequential word k of bank lo, and interleaved word 2k+1 is the same cell as sequential word k of bank hi.
- R4: An 8-bit write (req_size=0) enables neither bank, leaves memory unchanged and sets err_pulse in the following cycle.
- R5: A 16-bit write sets byte enables 0011 when o[1]=0 and 1100 when o[1]=1, with req_wdata[15:0] placed in the selected lanes. 32-bit and 64-bit writes enable all four lanes.
- R6: Reads of 8, 16 or 32 bits return the addressed little-endian bytes right-aligned and zero-extended on rsp_rdata.
- R7: A 64-bit access (req_size=3) in the interleaved window enables both banks in the same cycle at word o[22:3]. Bytes 0-3 go to or come from bank lo, and bytes 4-7 go to or come from bank hi.
- R8: A 64-bit access in the sequential window enables neither bank, returns no response and sets err_pulse in the following cycle.
- R9: Address bits below the transfer size, and req_addr[23], do not affect the access.
- R10: After reset, rsp_valid and err_pulse are low.
- R11: Every accepted read gives rsp_valid high for exactly the cycle after the request. rsp_valid is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0=8, 1=16, 2=32, 3=64 bits |
| req_addr | input | 25 | Bit 24 window select, bits 22:0 byte offset |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data, right-aligned, zero-extended |
| err_pulse | output | 1 | Rejected request, one cycle after it |
| lo_en | output | 1 | Bank lo access enable |
| lo_we | output | 1 | Bank lo write |
| lo_addr | output | 20 | Bank lo word address |
| lo_be | output | 4 | Bank lo byte enables |
| lo_wdata | output | 32 | Bank lo write data |
| lo_rdata | input | 32 | Bank lo read data, one cycle after enable |
| hi_en | output | 1 | Bank hi access enable |
| hi_we | output | 1 | Bank hi write |
| hi_addr | output | 20 | Bank hi word address |
| hi_be | output | 4 | Bank hi byte enables |
| hi_wdata | output | 32 | Bank hi write data |
| hi_rdata | input | 32 | Bank hi read data, one cycle after enable |

## Verification
The bank lines are a combinational function of the request, so they are due in the request cycle itself. The bench samples them 1 ns after it drives the request on the falling edge. Read data and the error flag each pass through one register, so both are due in the cycle after the request. The bench drops req_valid just after the rising edge and checks rsp_valid, rsp_rdata and err_pulse on the next falling edge. A byte-level reference memory, addressed through the window mappings, supplies every expected read value, including reads of a cell written through the other window.

// File: rtl/vrx_pkg.sv
package vrx_pkg;
    localparam int WIN_BIT = 24;
    localparam int HOST_AW = WIN_BIT + 1;
    localparam int OFS_W   = 23;
    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;
    localparam int LANE_W  = $clog2(LANES);
    localparam int NBANK   = 2;
    localparam int BANK_AW = OFS_W - 1 - LANE_W;
    localparam int HOST_DW = WORD_W * NBANK;

    typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} xfer_sz_e;

    typedef struct packed {
        logic               en;
        logic               we;
        logic [BANK_AW-1:0] addr;
        logic [LANES-1:0]   be;
        logic [WORD_W-1:0]  wdata;
    } bank_cmd_t;

    typedef struct packed {
        logic              rd;
        logic              bank;
        logic [LANE_W-1:0] lane;
        xfer_sz_e          sz;
    } rsp_ctl_t;

    function automatic logic [LANES-1:0] lane_be(xfer_sz_e sz, logic [LANE_W-1:0] lane);
        case (sz)
            SZ_B:    return LANES'(1) << lane;
            SZ_H:    return lane[1] ? 4'b1100 : 4'b0011;
            default: return '1;
        endcase
    endfunction
endpackage

// File: rtl/vrx_route.sv
module vrx_route
    import vrx_pkg::*;
(
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [1:0]                   req_size,
    input  logic [HOST_AW-1:0]           req_addr,
    input  logic [HOST_DW-1:0]           req_wdata,
    output bank_cmd_t [NBANK-1:0]        cmd,
    output rsp_ctl_t                     ctl,
    output logic                         bad
);
    xfer_sz_e            sz;
    logic                seq;
    logic                both;
    logic                sel;
    logic [OFS_W-1:0]    ofs;
    logic [BANK_AW-1:0]  widx;
    logic [WORD_W-1:0]   narrow_wd;

    assign sz   = xfer_sz_e'(req_size);
    assign seq  = req_addr[WIN_BIT];
    assign ofs  = req_addr[OFS_W-1:0];
    assign both = (sz == SZ_D);
    assign bad  = req_valid && ((req_write && sz == SZ_B) || (both && seq));

    always_comb begin
        if (seq) begin
            sel  = ofs[OFS_W-1];
            widx = ofs[OFS_W-2:LANE_W];
        end else begin
            sel  = ofs[LANE_W];
            widx = ofs[OFS_W-1:LANE_W+1];
        end
    end

    assign narrow_wd = (sz == SZ_H) ? {2{req_wdata[15:0]}} : req_wdata[WORD_W-1:0];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic SELF = 1'(b);
        always_comb begin
            cmd[b].en    = req_valid && !bad && (both || sel == SELF);
            cmd[b].we    = req_write;
            cmd[b].addr  = widx;
            cmd[b].be    = lane_be(sz, ofs[LANE_W-1:0]);
            cmd[b].wdata = both ? req_wdata[b*WORD_W +: WORD_W] : narrow_wd;
        end
    end

    always_comb begin
        ctl.rd   = req_valid && !req_write && !bad;
        ctl.bank = sel;
        ctl.lane = ofs[LANE_W-1:0];
        ctl.sz   = sz;
    end
endmodule

// File: rtl/vrx_resp.sv
module vrx_resp
    import vrx_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  rsp_ctl_t                      ctl_in,
    input  logic                          bad_in,
    input  logic [NBANK-1:0][WORD_W-1:0]  bank_rd,
    output logic                          rsp_valid,
    output logic [HOST_DW-1:0]            rsp_rdata,
    output logic                          err_pulse
);
    rsp_ctl_t           ctl_q;
    logic [WORD_W-1:0]  word;
    logic [WORD_W-1:0]  byte_sh;
    logic [WORD_W-1:0]  half_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '0;
            err_pulse <= 1'b0;
        end else begin
            ctl_q     <= ctl_in;
            err_pulse <= bad_in;
        end
    end

    assign rsp_valid = ctl_q.rd;
    assign word      = bank_rd[ctl_q.bank];
    assign byte_sh   = word >> {ctl_q.lane, 3'b000};
    assign half_sh   = word >> {ctl_q.lane[1], 4'b0000};

    always_comb begin
        if (!ctl_q.rd) begin
            rsp_rdata = '0;
        end else begin
            case (ctl_q.sz)
                SZ_B:    rsp_rdata = HOST_DW'(byte_sh[7:0]);
                SZ_H:    rsp_rdata = HOST_DW'(half_sh[15:0]);
                SZ_W:    rsp_rdata = HOST_DW'(word);
                default: rsp_rdata = bank_rd;
            endcase
        end
    end
endmodule

// File: rtl/vram_dual_bank_xlat.sv
module vram_dual_bank_xlat
    import vrx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic [HOST_AW-1:0]  req_addr,
    input  logic [HOST_DW-1:0]  req_wdata,
    output logic                rsp_valid,
    output logic [HOST_DW-1:0]  rsp_rdata,
    output logic                err_pulse,
    output logic                lo_en,
    output logic                lo_we,
    output logic [BANK_AW-1:0]  lo_addr,
    output logic [LANES-1:0]    lo_be,
    output logic [WORD_W-1:0]   lo_wdata,
    input  logic [WORD_W-1:0]   lo_rdata,
    output logic                hi_en,
    output logic                hi_we,
    output logic [BANK_AW-1:0]  hi_addr,
    output logic [LANES-1:0]    hi_be,
    output logic [WORD_W-1:0]   hi_wdata,
    input  logic [WORD_W-1:0]   hi_rdata
);
    bank_cmd_t [NBANK-1:0]  cmd;
    rsp_ctl_t               ctl;
    logic                   bad;

    vrx_route u_route (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cmd       (cmd),
        .ctl       (ctl),
        .bad       (bad)
    );

    vrx_resp u_resp (
        .clk       (clk),
        .rst       (rst),
        .ctl_in    (ctl),
        .bad_in    (bad),
        .bank_rd   ({hi_rdata, lo_rdata}),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .err_pulse (err_pulse)
    );

    assign lo_en    = cmd[0].en;
    assign lo_we    = cmd[0].we;
    assign lo_addr  = cmd[0].addr;
    assign lo_be    = cmd[0].be;
    assign lo_wdata = cmd[0].wdata;
    assign hi_en    = cmd[1].en;
    assign hi_we    = cmd[1].we;
    assign hi_addr  = cmd[1].addr;
    assign hi_be    = cmd[1].be;
    assign hi_wdata = cmd[1].wdata;
endmodule

// File: rtl/vrx_chk.sv
module vrx_chk
    import vrx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_write,
    input logic [1:0]          req_size,
    input logic [HOST_AW-1:0]  req_addr,
    input logic                rsp_valid,
    input logic                err_pulse,
    input logic                lo_en,
    input logic [BANK_AW-1:0]  lo_addr,
    input logic [LANES-1:0]    lo_be,
    input logic                hi_en,
    input logic [BANK_AW-1:0]  hi_addr
);
    logic wide_il;
    logic illegal;
    assign wide_il = req_size == 2'd3 && !req_addr[WIN_BIT];
    assign illegal = (req_write && req_size == 2'd0) || (req_size == 2'd3 && req_addr[WIN_BIT]);

    assert_single_bank_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid && !wide_il |-> !(lo_en && hi_en));

    assert_pair_bank_R7: assert property (@(posedge clk) disable iff (rst)
        req_valid && wide_il |-> lo_en && hi_en && lo_addr == hi_addr);

    assert_no_byte_write_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write && req_size == 2'd0 |-> !lo_en && !hi_en);

    assert_byte_write_err_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write && req_size == 2'd0 |=> err_pulse);

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(req_valid && illegal));

    assert_half_lanes_R5: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write && req_size == 2'd1 && lo_en |-> lo_be == (req_addr[1] ? 4'b1100 : 4'b0011));

    assert_read_resp_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_write && !illegal |=> rsp_valid);

    assert_resp_cause_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write && !illegal));
endmodule

bind vram_dual_bank_xlat vrx_chk u_chk (.*);

// File: tb/tb_vram_dual_bank_xlat.sv
`timescale 1ns/1ps
module tb_vram_dual_bank_xlat;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [24:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, err_pulse;
    logic [63:0] rsp_rdata;
    logic        lo_en, lo_we, hi_en, hi_we;
    logic [19:0] lo_addr, hi_addr;
    logic [3:0]  lo_be, hi_be;
    logic [31:0] lo_wdata, hi_wdata;
    logic [31:0] lo_rdata = '0;
    logic [31:0] hi_rdata = '0;

    int checks = 0;
    int errors = 0;
    logic [31:0] mlo [int];
    logic [31:0] mhi [int];
    logic [7:0]  shadow [int];

    always #10 clk = ~clk;

    vram_dual_bank_xlat dut (.*);

    always @(posedge clk) begin
        logic [31:0] t;
        if (lo_en) begin
            t = mlo.exists(int'(lo_addr)) ? mlo[int'(lo_addr)] : 32'd0;
            lo_rdata <= t;
            if (lo_we) begin
                for (int i = 0; i < 4; i++) if (lo_be[i]) t[i*8 +: 8] = lo_wdata[i*8 +: 8];
                mlo[int'(lo_addr)] = t;
            end
        end
    end

    always @(posedge clk) begin
        logic [31:0] t;
        if (hi_en) begin
            t = mhi.exists(int'(hi_addr)) ? mhi[int'(hi_addr)] : 32'd0;
            hi_rdata <= t;
            if (hi_we) begin
                for (int i = 0; i < 4; i++) if (hi_be[i]) t[i*8 +: 8] = hi_wdata[i*8 +: 8];
                mhi[int'(hi_addr)] = t;
            end
        end
    end

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int phys_of(bit seq, logic [22:0] o);
        if (seq) return int'({9'b0, o[22], o[21:2], o[1:0]});
        return int'({9'b0, o[2], o[22:3], o[1:0]});
    endfunction

    task automatic run_op(bit wr, int sz, bit seq, bit b23, logic [22:0] o,
                          logic [63:0] wd, string rtag);
        int          nb;
        bit          illegal;
        logic [22:0] base;
        logic [63:0] exp;
        bit          xb;
        logic [19:0] xw;
        nb      = 1 << sz;
        illegal = (wr && sz == 0) || (sz == 3 && seq);
        base    = o & ~23'(nb - 1);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = 2'(sz);
        req_addr  = {seq, b23, o}; req_wdata = wd;
        #1;
        if (illegal) begin
            check(!lo_en && !hi_en, wr ? "R4 bank lines" : "R8 bank lines",
                  {62'd0, hi_en, lo_en}, 64'd0);
        end else if (sz == 3) begin
            check(lo_en && hi_en && lo_addr == base[22:3] && hi_addr == base[22:3], "R7 both banks",
                  {22'd0, hi_addr, lo_addr, hi_en, lo_en}, {22'd0, base[22:3], base[22:3], 2'b11});
        end else begin
            xb = seq ? o[22] : o[2];
            xw = seq ? o[21:2] : o[22:3];
            check(lo_en == !xb && hi_en == xb && (xb ? hi_addr : lo_addr) == xw,
                  seq ? "R1 bank select" : "R2 bank select",
                  {42'd0, (xb ? hi_addr : lo_addr), hi_en, lo_en}, {42'd0, xw, xb, !xb});
            if (wr && sz == 1)
                check((xb ? hi_be : lo_be) == (o[1] ? 4'b1100 : 4'b0011), "R5 half lanes",
                      {60'd0, (xb ? hi_be : lo_be)}, {60'd0, (o[1] ? 4'b1100 : 4'b0011)});
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        check(err_pulse == illegal, illegal ? (wr ? "R4 err" : "R8 err") : "R4 no err",
              {63'd0, err_pulse}, {63'd0, illegal});
        if (illegal || wr) begin
            check(!rsp_valid, "R11 no resp", {63'd0, rsp_valid}, 64'd0);
        end else begin
            exp = '0;
            for (int i = 0; i < nb; i++) begin
                int p;
                p = phys_of(seq, base + 23'(i));
                exp[i*8 +: 8] = shadow.exists(p) ? shadow[p] : 8'd0;
            end
            check(rsp_valid, "R11 resp", {63'd0, rsp_valid}, 64'd1);
            check(rsp_rdata == exp, rtag, rsp_rdata, exp);
        end
        if (wr && !illegal)
            for (int i = 0; i < nb; i++) shadow[phys_of(seq, base + 23'(i))] = wd[i*8 +: 8];
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!rsp_valid && !err_pulse, "R10 reset", {62'd0, rsp_valid, err_pulse}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!rsp_valid && !err_pulse && !lo_en && !hi_en, "R10 idle",
              {60'd0, rsp_valid, err_pulse, lo_en, hi_en}, 64'd0);

        run_op(1, 2, 1, 0, 23'h400010, 64'h11223344, "R6");
        run_op(0, 2, 1, 0, 23'h400010, 64'd0, "R1 readback");
        run_op(1, 2, 1, 0, 23'h000014, 64'hA1B2C3D4, "R6");
        run_op(0, 2, 0, 0, 23'h000028, 64'd0, "R3 alias lo");
        run_op(1, 2, 0, 0, 23'h00002C, 64'h5566_7788, "R6");
        run_op(0, 2, 1, 0, 23'h400014, 64'd0, "R3 alias hi");
        run_op(1, 0, 1, 0, 23'h000014, 64'hAA, "R6");
        run_op(0, 2, 1, 0, 23'h000014, 64'd0, "R4 unchanged");
        run_op(1, 1, 1, 0, 23'h000016, 64'hBEEF, "R6");
        run_op(0, 2, 1, 0, 23'h000014, 64'd0, "R5 half write");
        run_op(0, 0, 1, 0, 23'h000017, 64'd0, "R6 byte read");
        run_op(0, 1, 0, 0, 23'h00002A, 64'd0, "R6 half read");
        run_op(1, 3, 0, 0, 23'h000030, 64'h0102030405060708, "R6");
        run_op(0, 3, 0, 0, 23'h000030, 64'd0, "R7 wide read");
        run_op(0, 2, 1, 0, 23'h000018, 64'd0, "R7 low half in lo bank");
        run_op(0, 2, 1, 0, 23'h400018, 64'd0, "R7 high half in hi bank");
        run_op(0, 3, 1, 0, 23'h000030, 64'd0, "R8");
        run_op(1, 3, 1, 0, 23'h000030, 64'hFFFF, "R8");
        run_op(0, 2, 1, 1, 23'h000015, 64'd0, "R9 ignored bits");
        run_op(0, 3, 0, 1, 23'h000035, 64'd0, "R9 ignored bits wide");

        for (int n = 0; n < 400; n++) begin
            bit          seq, wr;
            int          sz;
            logic [22:0] o;
            seq = 1'($urandom % 2);
            wr  = 1'($urandom % 2);
            sz  = int'($urandom % 4);
            if (seq) o = {1'($urandom % 2), 20'($urandom % 16), 2'($urandom % 4)};
            else     o = 23'(($urandom % 32) * 4 + ($urandom % 4));
            run_op(wr, sz, seq, 1'($urandom % 2), o, {$urandom, $urandom}, "R6 random read");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule